// File: doc/BRIEF.md
# Host Bus Port with Multiplexed and Separate Addressing

This block sits between an external host processor and the register and memory space of a switching device. A static strap chooses one of two addressing schemes. With separate addressing, the address comes in on its own pins. With multiplexed addressing, the address shares the 8-bit data bus and is captured when the address-latch input falls. A second strap picks the strobe protocol used with multiplexed addressing. In the first protocol, an active-high data strobe works with a read/write direction pin. In the second, separate active-low read and write strobes are used. Separate addressing always uses the data-strobe protocol.

All host pins are asynchronous. They pass through a synchronizer of configurable depth before any decoding. Once chip select and a valid strobe are seen, the port does three things. It issues one internal read pulse at the start of the cycle. It waits a fixed number of internal clocks. It then either commits the write data in a single one-cycle write pulse, or latches the read data for the host. At that point it drives the active-low transfer acknowledge, which stands for the enable of an open-drain pull-down. The acknowledge stays asserted until the host drops the strobe or chip select.

The internal side is a plain strobe interface. It has no back-pressure: the register space must return read data in the cycle after the read pulse. The upper two address bits select one of four target regions.

Top module: `hbi_host_port`

## Requirements
- R1: With `mux_mode` high, the transfer address is taken from `ad_in`. With it low, the address is taken from `addr_in`, and `ale` and the earlier contents of `ad_in` are ignored.
- R2: With multiplexed addressing, the address is the value on `ad_in` when the synchronized `ale` falls. Later changes on `ad_in` during the data phase do not change it.
- R3: While `cs_n` is high, no strobe starts a transfer: `reg_wr` and `reg_rd` stay low, `ack_n` stays high, `ad_oe` stays low, and the register contents are left unchanged.
- R4: In the data-strobe protocol (separate addressing, or multiplexed with `intel_style` low), `ds_rd` high marks a cycle. In that protocol `rw_wr` high means read and low means write.
- R5: In the read/write-strobe protocol (`mux_mode` and `intel_style` both high), `ds_rd` low requests a read and `rw_wr` low requests a write.
- R6: `ack_n` falls exactly SYNC_STAGES+1+ACK_DLY clock edges after a valid strobe and chip select are applied, and stays low while they are held. It returns high exactly SYNC_STAGES+1 edges after they are released.
- R7: `ad_oe` is high only during a read cycle with chip select asserted. When `ack_n` is low in a read, `ad_out` carries the data of the addressed location.
- R8: Each write cycle produces exactly one `reg_wr` pulse, however long the strobe is held. The pulse carries the cycle's address and the data present on `ad_in`.
- R9: `reg_sel` is one-hot and decodes `reg_addr[ADDR_W-1:ADDR_W-2]`: 00 sets bit 0 (control), 01 sets bit 1 (data memory), 10 sets bit 2 (connection low), 11 sets bit 3 (connection high).
- R10: After reset, `ack_n` is high and `ad_oe`, `reg_wr` and `reg_rd` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mux_mode | input | 1 | Strap: 1 = multiplexed address/data, 0 = separate address pins |
| intel_style | input | 1 | Strap: 1 = active-low read/write strobes (multiplexed only) |
| cs_n | input | 1 | Chip select, active low |
| ds_rd | input | 1 | Data strobe (active high) or read strobe (active low) |
| rw_wr | input | 1 | Direction (1 = read) or write strobe (active low) |
| ale | input | 1 | Address latch enable, address taken on its fall |
| addr_in | input | ADDR_W | Separate address pins |
| ad_in | input | DATA_W | Host data / multiplexed address in |
| ad_out | output | DATA_W | Read data toward the host |
| ad_oe | output | 1 | Host bus output enable |
| ack_n | output | 1 | Transfer acknowledge, low = pull line low |
| reg_addr | output | ADDR_W | Internal address of the current cycle |
| reg_sel | output | 4 | One-hot region select |
| reg_wdata | output | DATA_W | Internal write data |
| reg_wr | output | 1 | One-cycle write commit pulse |
| reg_rd | output | 1 | One-cycle read request pulse |
| reg_rdata | input | DATA_W | Read data, valid the cycle after `reg_rd` |

## Verification
The bench builds the port with SYNC_STAGES=2 and ACK_DLY=3, so the acknowledge latency is six edges. This lets the wait state run for several cycles, which exercises a counter that passes through intermediate values before completing. It uses 8-bit address and data, so the two region bits and a full byte address can both be driven through the multiplexed bus. Every addressing mode and strobe protocol is run against a small model memory. The bench counts acknowledge edges exactly and holds a strobe for a long time to look for a repeated write.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE = 2'd0,
    CYC_WAIT = 2'd1,
    CYC_ACK  = 2'd2
  } cyc_state_t;

  localparam int NUM_REGIONS = 4;
  localparam int REGION_BITS = 2;
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= INIT;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[s] <= INIT;
          else        chain[s] <= chain[s-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hbi_strobe_dec.sv
module hbi_strobe_dec (
  input  logic mux_mode,
  input  logic intel_style,
  input  logic cs_n,
  input  logic ds_rd,
  input  logic rw_wr,
  output logic rd_req,
  output logic wr_req
);
  logic sep_strobes;

  assign sep_strobes = mux_mode & intel_style;

  always_comb begin
    rd_req = 1'b0;
    wr_req = 1'b0;
    if (!cs_n) begin
      if (sep_strobes) begin
        rd_req = ~ds_rd & rw_wr;
        wr_req = ~rw_wr & ds_rd;
      end else begin
        rd_req = ds_rd & rw_wr;
        wr_req = ds_rd & ~rw_wr;
      end
    end
  end
endmodule

// File: rtl/hbi_addr_latch.sv
module hbi_addr_latch #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mux_mode,
  input  logic              ale,
  input  logic [DATA_W-1:0] ad,
  input  logic [ADDR_W-1:0] addr_sep,
  output logic [ADDR_W-1:0] addr
);
  localparam int CAP_W = (DATA_W < ADDR_W) ? DATA_W : ADDR_W;

  logic              ale_q;
  logic              ale_fall;
  logic [ADDR_W-1:0] lat_q;
  logic [ADDR_W-1:0] ad_ext;

  always_comb begin
    ad_ext = '0;
    ad_ext[CAP_W-1:0] = ad[CAP_W-1:0];
  end

  assign ale_fall = ale_q & ~ale;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ale_q <= 1'b0;
      lat_q <= '0;
    end else begin
      ale_q <= ale;
      if (mux_mode && ale_fall) lat_q <= ad_ext;
    end

  assign addr = mux_mode ? lat_q : addr_sep;

  // R2: a falling latch enable captures the bus value of that cycle
  assert_addr_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mux_mode && ale_q && !ale) |=> (lat_q == $past(ad_ext)));
endmodule

// File: rtl/hbi_cycle_ctl.sv
module hbi_cycle_ctl
  import hbi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int ACK_DLY = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] ad,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd,
  output logic [DATA_W-1:0] rdata_q,
  output logic              ack_n
);
  localparam int CNT_W = (ACK_DLY < 2) ? 1 : $clog2(ACK_DLY);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACK_DLY - 1);

  cyc_state_t       state;
  logic [CNT_W-1:0] cnt;
  logic             is_wr_q;
  logic             req;

  assign req = rd_req | wr_req;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state     <= CYC_IDLE;
      cnt       <= '0;
      is_wr_q   <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      rdata_q   <= '0;
      reg_wr    <= 1'b0;
      reg_rd    <= 1'b0;
    end else begin
      reg_wr <= 1'b0;
      reg_rd <= 1'b0;
      case (state)
        CYC_IDLE: if (req) begin
          state    <= CYC_WAIT;
          cnt      <= '0;
          is_wr_q  <= wr_req;
          reg_addr <= addr;
          reg_rd   <= rd_req;
        end
        CYC_WAIT: begin
          if (!req) begin
            state <= CYC_IDLE;
          end else if (cnt == CNT_LAST) begin
            state <= CYC_ACK;
            if (is_wr_q) begin
              reg_wr    <= 1'b1;
              reg_wdata <= ad;
            end else begin
              rdata_q <= reg_rdata;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        CYC_ACK: if (!req) state <= CYC_IDLE;
        default: state <= CYC_IDLE;
      endcase
    end

  assign ack_n = (state != CYC_ACK);

  // R8: the commit strobe never lasts two cycles
  assert_single_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);
  // R6: acknowledge only ever starts while a request was present
  assert_ack_after_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) |-> $past(req));
  // R6: released request drops the acknowledge on the next edge
  assert_ack_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n && !req) |=> ack_n);
endmodule

// File: rtl/hbi_host_port.sv
module hbi_host_port
  import hbi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter int ACK_DLY = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mux_mode,
  input  logic                   intel_style,
  input  logic                   cs_n,
  input  logic                   ds_rd,
  input  logic                   rw_wr,
  input  logic                   ale,
  input  logic [ADDR_W-1:0]      addr_in,
  input  logic [DATA_W-1:0]      ad_in,
  output logic [DATA_W-1:0]      ad_out,
  output logic                   ad_oe,
  output logic                   ack_n,
  output logic [ADDR_W-1:0]      reg_addr,
  output logic [NUM_REGIONS-1:0] reg_sel,
  output logic [DATA_W-1:0]      reg_wdata,
  output logic                   reg_wr,
  output logic                   reg_rd,
  input  logic [DATA_W-1:0]      reg_rdata
);
  localparam int CTL_W = 4;
  localparam int DAT_W = ADDR_W + DATA_W;

  logic [CTL_W-1:0]  ctl_s;
  logic [DAT_W-1:0]  dat_s;
  logic              cs_s, ds_s, rw_s, ale_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] ad_s;
  logic [ADDR_W-1:0] cyc_addr;
  logic              rd_req, wr_req;

  hbi_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .INIT(4'b0101)) u_sync_ctl (
    .clk(clk), .rst_n(rst_n),
    .d({ale, rw_wr, ds_rd, cs_n}),
    .q(ctl_s)
  );

  hbi_sync #(.W(DAT_W), .STAGES(SYNC_STAGES), .INIT('0)) u_sync_dat (
    .clk(clk), .rst_n(rst_n),
    .d({addr_in, ad_in}),
    .q(dat_s)
  );

  assign {ale_s, rw_s, ds_s, cs_s} = ctl_s;
  assign {addr_s, ad_s} = dat_s;

  hbi_strobe_dec u_dec (
    .mux_mode(mux_mode), .intel_style(intel_style),
    .cs_n(cs_s), .ds_rd(ds_s), .rw_wr(rw_s),
    .rd_req(rd_req), .wr_req(wr_req)
  );

  hbi_addr_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_alat (
    .clk(clk), .rst_n(rst_n), .mux_mode(mux_mode),
    .ale(ale_s), .ad(ad_s), .addr_sep(addr_s), .addr(cyc_addr)
  );

  hbi_cycle_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .ACK_DLY(ACK_DLY)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .rd_req(rd_req), .wr_req(wr_req),
    .addr(cyc_addr), .ad(ad_s), .reg_rdata(reg_rdata),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd),
    .rdata_q(ad_out), .ack_n(ack_n)
  );

  assign ad_oe = rd_req;

  genvar g;
  generate
    for (g = 0; g < NUM_REGIONS; g++) begin : g_region
      assign reg_sel[g] = (reg_addr[ADDR_W-1 -: REGION_BITS] == REGION_BITS'(g));
    end
  endgenerate

  // R3: no internal access may follow a deselected cycle
  assert_no_access_unselected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || reg_rd) |-> !$past(cs_s));
  // R7: the host bus is never driven while a write commits
  assert_oe_not_in_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> !reg_wr);
  // R9: every internal access targets exactly one region
  assert_one_region_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || reg_rd) |-> ($countones(reg_sel) == 1));
endmodule

// File: tb/tb_hbi_host_port.sv
module tb_hbi_host_port;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int SYN = 2;
  localparam int DLY = 3;
  localparam int LAT = SYN + 1 + DLY;
  localparam int REL = SYN + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mux_mode = 1'b0, intel_style = 1'b0;
  logic cs_n = 1'b1, ds_rd = 1'b0, rw_wr = 1'b1, ale = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [DW-1:0] ad_in = '0;
  logic [DW-1:0] ad_out;
  logic ad_oe, ack_n, reg_wr, reg_rd;
  logic [AW-1:0] reg_addr;
  logic [3:0] reg_sel;
  logic [DW-1:0] reg_wdata, reg_rdata;

  logic [DW-1:0] mem [256];
  int n_checks = 0, n_fail = 0, wr_count = 0;
  logic [AW-1:0] last_wr_addr;
  logic [DW-1:0] last_wr_data;
  logic [3:0] last_wr_sel;
  bit done = 0;

  always #10 clk = ~clk;

  hbi_host_port #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(SYN), .ACK_DLY(DLY)) dut (
    .clk(clk), .rst_n(rst_n), .mux_mode(mux_mode), .intel_style(intel_style),
    .cs_n(cs_n), .ds_rd(ds_rd), .rw_wr(rw_wr), .ale(ale),
    .addr_in(addr_in), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .ack_n(ack_n), .reg_addr(reg_addr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata)
  );

  assign reg_rdata = mem[reg_addr];

  always @(negedge clk) if (rst_n && reg_wr) begin
    wr_count++;
    last_wr_addr = reg_addr;
    last_wr_data = reg_wdata;
    last_wr_sel  = reg_sel;
    mem[reg_addr] = reg_wdata;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  task automatic idle_strobes(input bit intel);
    cs_n = 1'b1;
    ds_rd = intel ? 1'b1 : 1'b0;
    rw_wr = 1'b1;
  endtask

  // One host transfer; checks ack timing (R6) and output enable (R7)
  task automatic host_cycle(input bit mux, input bit intel, input bit rd,
                            input logic [7:0] a, input logic [7:0] d,
                            input int hold, output logic [7:0] rdv);
    @(negedge clk);
    mux_mode = mux; intel_style = intel; idle_strobes(intel);
    if (mux) begin
      addr_in = ~a; ad_in = a; ale = 1'b1;
      repeat (2) @(negedge clk);
      ale = 1'b0;
      repeat (4) @(negedge clk);
      ad_in = d;
    end else begin
      addr_in = a; ad_in = d;
    end
    @(negedge clk);
    cs_n = 1'b0;
    if (intel) begin
      if (rd) ds_rd = 1'b0; else rw_wr = 1'b0;
    end else begin
      ds_rd = 1'b1; rw_wr = rd;
    end
    for (int n = 1; n <= LAT; n++) begin
      @(negedge clk);
      if (n == LAT - 1) check(ack_n == 1'b1, "R6 ack early", ack_n, 1);
      if (n == LAT)     check(ack_n == 1'b0, "R6 ack latency", ack_n, 0);
    end
    check(ad_oe == rd, "R7 ad_oe during cycle", ad_oe, rd);
    rdv = ad_out;
    repeat (hold) @(negedge clk);
    check(ack_n == 1'b0, "R6 ack held", ack_n, 0);
    idle_strobes(intel);
    for (int n = 1; n <= REL; n++) begin
      @(negedge clk);
      if (n == REL - 1) check(ack_n == 1'b0, "R6 ack release early", ack_n, 0);
      if (n == REL)     check(ack_n == 1'b1, "R6 ack release", ack_n, 1);
    end
    check(ad_oe == 1'b0, "R7 ad_oe after release", ad_oe, 0);
  endtask

  task automatic t_reset();
    check(ack_n == 1'b1, "R10 ack_n", ack_n, 1);
    check(ad_oe == 1'b0, "R10 ad_oe", ad_oe, 0);
    check(reg_wr == 1'b0 && reg_rd == 1'b0, "R10 strobes", {reg_wr, reg_rd}, 0);
  endtask

  task automatic t_sep_write_read();
    logic [7:0] v;
    int c0 = wr_count;
    host_cycle(0, 0, 0, 8'h47, 8'h3C, 0, v);
    check(wr_count == c0 + 1, "R4 R8 one write", wr_count - c0, 1);
    check(last_wr_addr == 8'h47, "R1 separate address", last_wr_addr, 8'h47);
    check(last_wr_data == 8'h3C, "R8 write data", last_wr_data, 8'h3C);
    check(last_wr_sel == 4'b0010, "R9 data memory region", last_wr_sel, 4'b0010);
    host_cycle(0, 0, 1, 8'h47, 8'h00, 2, v);
    check(v == 8'h3C, "R4 R7 read back", v, 8'h3C);
    check(wr_count == c0 + 1, "R4 read makes no write", wr_count - c0, 1);
  endtask

  task automatic t_moto_mux();
    logic [7:0] v;
    int c0 = wr_count;
    host_cycle(1, 0, 0, 8'hA5, 8'h99, 0, v);
    check(wr_count == c0 + 1, "R4 mux write count", wr_count - c0, 1);
    check(last_wr_addr == 8'hA5, "R1 R2 latched address", last_wr_addr, 8'hA5);
    check(last_wr_data == 8'h99, "R2 data phase", last_wr_data, 8'h99);
    check(last_wr_sel == 4'b0100, "R9 connection low region", last_wr_sel, 4'b0100);
    host_cycle(1, 0, 1, 8'hA5, 8'h00, 0, v);
    check(v == 8'h99, "R4 mux read", v, 8'h99);
  endtask

  task automatic t_intel_mux();
    logic [7:0] v;
    int c0 = wr_count;
    host_cycle(1, 1, 0, 8'hE1, 8'h77, 12, v);
    check(wr_count == c0 + 1, "R5 R8 long strobe single write", wr_count - c0, 1);
    check(last_wr_addr == 8'hE1, "R5 write address", last_wr_addr, 8'hE1);
    check(last_wr_sel == 4'b1000, "R9 connection high region", last_wr_sel, 4'b1000);
    host_cycle(1, 1, 1, 8'hE1, 8'h00, 1, v);
    check(v == 8'h77, "R5 R7 read data", v, 8'h77);
  endtask

  task automatic t_ctrl_region();
    logic [7:0] v;
    host_cycle(0, 0, 0, 8'h05, 8'hC3, 0, v);
    check(last_wr_sel == 4'b0001, "R9 control region", last_wr_sel, 4'b0001);
    check(mem[8'h05] == 8'hC3, "R8 control write", mem[8'h05], 8'hC3);
  endtask

  task automatic t_deselected();
    logic [7:0] v;
    int c0 = wr_count;
    bit ack_seen = 0, oe_seen = 0;
    @(negedge clk);
    mux_mode = 0; intel_style = 0;
    addr_in = 8'h47; ad_in = 8'hFF;
    cs_n = 1'b1; ds_rd = 1'b1; rw_wr = 1'b0;
    for (int n = 0; n < 12; n++) begin
      @(negedge clk);
      if (!ack_n) ack_seen = 1;
      if (ad_oe) oe_seen = 1;
    end
    rw_wr = 1'b1;
    for (int n = 0; n < 12; n++) begin
      @(negedge clk);
      if (!ack_n) ack_seen = 1;
      if (ad_oe) oe_seen = 1;
    end
    idle_strobes(0);
    repeat (REL) @(negedge clk);
    check(!ack_seen, "R3 no ack when deselected", ack_seen, 0);
    check(!oe_seen, "R3 no bus drive when deselected", oe_seen, 0);
    check(wr_count == c0, "R3 no write when deselected", wr_count - c0, 0);
    host_cycle(0, 0, 1, 8'h47, 8'h00, 0, v);
    check(v == 8'h3C, "R3 location unchanged", v, 8'h3C);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_sep_write_read();
    t_moto_mux();
    t_intel_mux();
    t_ctrl_region();
    t_deselected();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    finish_run();
  end
endmodule